// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block sits between an instruction fetch stream and the issue stage of a small 32-bit load/store core whose instructions are built from 16-bit words. Words arrive one at a time over a valid/ready handshake. The first word of each instruction is a header that holds an opcode, an operand-size mode and two 4-bit register fields. The block turns each header, together with any immediate words that follow it, into one decoded record. The record is presented on a registered valid/ready output.

An instruction has either a register operand or an immediate operand. An immediate operand is one extra word, sign-extended to 32 bits, or two extra words. A small opcode group can only add a register or immediate value to the stack pointer, or subtract one from it. The block flags that group separately. Opcodes outside the defined set are flagged as illegal and never consume extension words.

Top module: `vlen_decode`

## Requirements
- R1: The header is decoded as opcode = word[15:10], mode = word[9:8], source register = word[7:4] and destination register = word[3:0]. For mode 00 (byte), 01 (word) or 10 (long), the instruction is one word long and reports out_has_imm = 0 and out_imm = 0. Its record appears on the outputs in the cycle after the header is accepted.
- R2: For a legal opcode with mode 11 (immediate), opcode bit 0 (word bit 10) clear means exactly one extension word follows. out_imm is that word sign-extended to 32 bits, and out_has_imm = 1.
- R3: For a legal opcode with mode 11 and opcode bit 0 set, exactly two extension words follow, most-significant word first, and out_imm = {first, second}.
- R4: In immediate mode the source register field has no effect: out_src reads 0.
- R5: out_valid does not rise while extension words are still due. It rises in the cycle after the last word of the instruction is accepted.
- R6: While out_valid = 1 and out_ready = 0, in_ready is 0 and every output holds its value.
- R7: Opcodes 0x3C to 0x3F form the stack-pointer group and report out_sp = 1. Opcode bit 1 clear means add and set means subtract. Opcode bit 0 chooses the immediate size as in R2 and R3.
- R8: Opcodes 0x20 to 0x3B report out_illegal = 1, out_has_imm = 0, out_sp = 0 and out_imm = 0, in any mode. The next word is taken as a new header.
- R9: A synchronous active-high reset clears out_valid and discards any instruction that is partly collected.
- R10: With out_ready = 1 and no new input, out_valid stays high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction word is offered |
| in_word | input | 16 | Instruction or extension word |
| in_ready | output | 1 | Word accepted at the next edge when in_valid is high |
| out_valid | output | 1 | A decoded record is on the outputs |
| out_ready | input | 1 | Consumer takes the record at the next edge |
| out_opcode | output | 6 | Opcode |
| out_mode | output | 2 | Operand-size / immediate mode |
| out_src | output | 4 | Source register (0 in immediate mode) |
| out_dst | output | 4 | Destination register |
| out_imm | output | 32 | Immediate value |
| out_has_imm | output | 1 | Record carries an immediate |
| out_sp | output | 1 | Stack-pointer add/sub form |
| out_illegal | output | 1 | Opcode outside the defined set |

## Verification
The assertions check, on every cycle, the rules that can be seen at the output alone. These are: stalling and holding the output under backpressure, the single-cycle valid pulse, the zeroed source field in immediate mode, sign extension of short immediates, and the clean shape of illegal and stack-pointer records. Only the bench scenarios can show that the right number of extension words is consumed and that their order makes up the immediate. They also show that an illegal header leaves the next word as a header, and that a reset in the middle of an instruction throws away the partial state.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  parameter int WORD_W = 16;
  parameter int DATA_W = 32;
  parameter int REG_W  = 4;
  parameter int OPC_W  = 6;
  parameter int MODE_W = 2;
  parameter int EXT_MAX = DATA_W / WORD_W;
  parameter int CNT_W   = $clog2(EXT_MAX + 1);
  parameter int ACC_W   = DATA_W - WORD_W;

  typedef enum logic [MODE_W-1:0] {
    MD_BYTE = 2'b00,
    MD_WORD = 2'b01,
    MD_LONG = 2'b10,
    MD_IMM  = 2'b11
  } mode_e;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [MODE_W-1:0] mode;
    logic [REG_W-1:0]  src;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] imm;
    logic              has_imm;
    logic              sp;
    logic              illegal;
  } dec_t;
endpackage

// File: rtl/vlen_classify.sv
module vlen_classify
  import vlen_pkg::*;
#(
  parameter int GEN_OPS = 32,
  parameter int SP_BASE = 60,
  parameter bit SP_EN   = 1'b1
) (
  input  logic [WORD_W-1:0] word,
  output dec_t              hdr,
  output logic              need_ext,
  output logic              ext_long
);
  logic [OPC_W-1:0]  opc;
  logic [MODE_W-1:0] mode;
  logic              gen_hit;
  logic              sp_hit;
  logic              legal;
  logic              imm_mode;

  assign opc  = word[WORD_W-1 -: OPC_W];
  assign mode = word[WORD_W-OPC_W-1 -: MODE_W];

  assign gen_hit = ({1'b0, opc} < (OPC_W+1)'(GEN_OPS));

  generate
    if (SP_EN) begin : g_sp
      assign sp_hit = ({1'b0, opc} >= (OPC_W+1)'(SP_BASE));
    end else begin : g_nosp
      assign sp_hit = 1'b0;
    end
  endgenerate

  assign legal    = gen_hit | sp_hit;
  assign imm_mode = legal && (mode == MD_IMM);
  assign need_ext = imm_mode;
  assign ext_long = opc[0];

  always_comb begin
    hdr         = '0;
    hdr.opc     = opc;
    hdr.mode    = mode;
    hdr.src     = imm_mode ? '0 : word[2*REG_W-1 -: REG_W];
    hdr.dst     = word[REG_W-1:0];
    hdr.imm     = '0;
    hdr.has_imm = imm_mode;
    hdr.sp      = legal & sp_hit;
    hdr.illegal = ~legal;
  end
endmodule

// File: rtl/vlen_collect.sv
module vlen_collect
  import vlen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  input  dec_t              hdr_in,
  input  logic              need_ext,
  input  logic              ext_long,
  output logic              done,
  output dec_t              result
);
  logic                  busy;
  logic [CNT_W-1:0]      left;
  logic                  long_q;
  dec_t                  hdr_q;
  logic [ACC_W-1:0]      acc;
  logic [ACC_W+WORD_W-1:0] cat;

  assign cat = {acc, word};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      left   <= '0;
      long_q <= 1'b0;
      hdr_q  <= '0;
      acc    <= '0;
    end else if (take) begin
      if (!busy) begin
        if (need_ext) begin
          busy   <= 1'b1;
          hdr_q  <= hdr_in;
          long_q <= ext_long;
          left   <= ext_long ? CNT_W'(EXT_MAX) : CNT_W'(1);
          acc    <= '0;
        end
      end else begin
        acc  <= cat[ACC_W-1:0];
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    done   = 1'b0;
    result = hdr_in;
    if (take) begin
      if (!busy) begin
        done   = ~need_ext;
        result = hdr_in;
      end else if (left == CNT_W'(1)) begin
        done   = 1'b1;
        result = hdr_q;
        result.imm = long_q ? cat[DATA_W-1:0]
                            : {{ACC_W{word[WORD_W-1]}}, word};
      end
    end
  end
endmodule

// File: rtl/vlen_outreg.sv
module vlen_outreg
  import vlen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  dec_t d,
  input  logic pop,
  output logic valid,
  output dec_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vlen_decode.sv
module vlen_decode
  import vlen_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OPC_W-1:0]  out_opcode,
  output logic [MODE_W-1:0] out_mode,
  output logic [REG_W-1:0]  out_src,
  output logic [REG_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_imm,
  output logic              out_has_imm,
  output logic              out_sp,
  output logic              out_illegal
);
  dec_t hdr;
  dec_t res;
  dec_t q;
  logic need_ext;
  logic ext_long;
  logic take;
  logic done;

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  vlen_classify u_cls (
    .word     (in_word),
    .hdr      (hdr),
    .need_ext (need_ext),
    .ext_long (ext_long)
  );

  vlen_collect u_col (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .word     (in_word),
    .hdr_in   (hdr),
    .need_ext (need_ext),
    .ext_long (ext_long),
    .done     (done),
    .result   (res)
  );

  vlen_outreg u_out (
    .clk   (clk),
    .rst   (rst),
    .load  (done),
    .d     (res),
    .pop   (out_ready),
    .valid (out_valid),
    .q     (q)
  );

  assign out_opcode  = q.opc;
  assign out_mode    = q.mode;
  assign out_src     = q.src;
  assign out_dst     = q.dst;
  assign out_imm     = q.imm;
  assign out_has_imm = q.has_imm;
  assign out_sp      = q.sp;
  assign out_illegal = q.illegal;
endmodule

// File: rtl/vlen_decode_chk.sv
module vlen_decode_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [5:0]  out_opcode,
  input logic [1:0]  out_mode,
  input logic [3:0]  out_src,
  input logic [3:0]  out_dst,
  input logic [31:0] out_imm,
  input logic        out_has_imm,
  input logic        out_sp,
  input logic        out_illegal
);
  p_src_ignored_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_has_imm |-> out_src == 4'h0);

  p_ready_low_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_opcode)
      && $stable(out_dst) && $stable(out_src) && $stable(out_mode));

  p_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_illegal_plain_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_illegal |-> !out_has_imm && !out_sp && out_imm == 32'h0);

  p_sp_group_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sp |-> out_opcode[5:2] == 4'hF && !out_illegal);

  p_imm_mode_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_has_imm == (out_mode == 2'b11 && !out_illegal));

  p_short_sext_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_has_imm && !out_opcode[0] |-> out_imm[31:16] == {16{out_imm[15]}});

  p_reg_noimm_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_has_imm |-> out_imm == 32'h0);

  p_reset_r9: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind vlen_decode vlen_decode_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_opcode  (out_opcode),
  .out_mode    (out_mode),
  .out_src     (out_src),
  .out_dst     (out_dst),
  .out_imm     (out_imm),
  .out_has_imm (out_has_imm),
  .out_sp      (out_sp),
  .out_illegal (out_illegal)
);

// File: tb/vlen_decode_test.sv
`timescale 1ns/1ps
module vlen_decode_test;
  import vlen_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  out_opcode;
  logic [1:0]  out_mode;
  logic [3:0]  out_src;
  logic [3:0]  out_dst;
  logic [31:0] out_imm;
  logic        out_has_imm;
  logic        out_sp;
  logic        out_illegal;

  vlen_decode uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_opcode(out_opcode), .out_mode(out_mode), .out_src(out_src),
    .out_dst(out_dst), .out_imm(out_imm), .out_has_imm(out_has_imm),
    .out_sp(out_sp), .out_illegal(out_illegal)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  dec_t        expq[$];
  string       tagq[$];
  logic [15:0] wq[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] hw(input int opc, input int mode, input int src, input int dst);
    return {opc[5:0], mode[1:0], src[3:0], dst[3:0]};
  endfunction

  function automatic dec_t model(input logic [15:0] h, input logic [15:0] e0, input logic [15:0] e1);
    dec_t d;
    logic [5:0] o;
    bit legal;
    o = h[15:10];
    legal = (o < 6'd32) || (o >= 6'd60);
    d = '0;
    d.opc = o; d.mode = h[9:8]; d.src = h[7:4]; d.dst = h[3:0];
    d.illegal = !legal;
    if (legal) begin
      d.sp = (o >= 6'd60);
      if (h[9:8] == 2'b11) begin
        d.has_imm = 1'b1;
        d.src = 4'h0;
        d.imm = o[0] ? {e0, e1} : {{16{e0[15]}}, e0};
      end
    end
    return d;
  endfunction

  function automatic string kind(input dec_t d);
    if (d.illegal) return "R8";
    if (d.sp) return "R7";
    if (d.has_imm) return d.opc[0] ? "R3" : "R2";
    return "R1";
  endfunction

  task automatic push_exp(input logic [15:0] h, input logic [15:0] e0, input logic [15:0] e1, input string tag);
    dec_t d;
    d = model(h, e0, e1);
    expq.push_back(d);
    tagq.push_back(tag == "" ? kind(d) : tag);
  endtask

  task automatic queue_instr(input logic [15:0] h, input logic [15:0] e0, input logic [15:0] e1, input string tag);
    dec_t d;
    d = model(h, e0, e1);
    push_exp(h, e0, e1, tag);
    wq.push_back(h);
    if (d.has_imm) begin
      wq.push_back(e0);
      if (d.opc[0]) wq.push_back(e1);
    end
  endtask

  task automatic pop_check();
    dec_t got;
    dec_t e;
    string t;
    got = {out_opcode, out_mode, out_src, out_dst, out_imm, out_has_imm, out_sp, out_illegal};
    if (expq.size() == 0) begin
      chk(1'b0, "R5 unexpected record", 64'(got.opc), 64'hFFFF);
    end else begin
      e = expq.pop_front();
      t = tagq.pop_front();
      chk(got == e, t, {got.opc, got.src, got.dst, got.has_imm, got.sp, got.illegal, got.imm},
          {e.opc, e.src, e.dst, e.has_imm, e.sp, e.illegal, e.imm});
    end
  endtask

  task automatic step(input logic iv, input logic [15:0] w, input logic ordy, output logic took);
    @(negedge clk);
    in_valid = iv; in_word = w; out_ready = ordy;
    #1;
    if (out_valid && out_ready) pop_check();
    took = iv && in_ready;
  endtask

  task automatic run(input int ready_pct);
    logic took;
    logic iv;
    logic ordy;
    int guard;
    while (wq.size() > 0) begin
      iv = (($urandom % 100) < 80);
      ordy = (($urandom % 100) < ready_pct);
      step(iv, wq[0], ordy, took);
      if (took) void'(wq.pop_front());
    end
    guard = 0;
    while (expq.size() > 0 && guard < 50) begin
      step(1'b0, 16'h0, 1'b1, took);
      guard++;
    end
    chk(expq.size() == 0, "R5 records missing", 64'(expq.size()), 64'h0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      bad++; total++;
      $display("FAIL R5 watchdog got=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic took;
    logic [15:0] h1;
    logic [15:0] h2;
    logic [3:0]  dsave;
    void'($urandom(32'h5eed1234));

    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R9 reset out_valid", 64'(out_valid), 64'h0);
    chk(in_ready == 1'b1, "R9 reset in_ready", 64'(in_ready), 64'h1);
    @(negedge clk); rst = 1'b0;

    // R1: register form, one-cycle latency, then R10 single pulse
    h1 = hw(5, 2, 3, 7);
    push_exp(h1, 16'h0, 16'h0, "R1");
    step(1'b1, h1, 1'b1, took);
    chk(took, "R1 header accepted", 64'(took), 64'h1);
    step(1'b0, 16'h0, 1'b1, took);
    chk(expq.size() == 0, "R1 latency", 64'(expq.size()), 64'h0);
    step(1'b0, 16'h0, 1'b1, took);
    chk(out_valid == 1'b0, "R10 single pulse", 64'(out_valid), 64'h0);

    // R2: short negative immediate sign-extended
    queue_instr(hw(2, 3, 0, 3), 16'h8001, 16'h0, "R2");
    run(100);

    // R3 and R5: long immediate, MSW first, no early valid
    h1 = hw(3, 3, 0, 9);
    push_exp(h1, 16'hDEAD, 16'hBEEF, "R3");
    step(1'b1, h1, 1'b1, took);
    step(1'b0, 16'h0, 1'b1, took);
    chk(out_valid == 1'b0, "R5 after header", 64'(out_valid), 64'h0);
    step(1'b1, 16'hDEAD, 1'b1, took);
    step(1'b0, 16'h0, 1'b1, took);
    chk(out_valid == 1'b0, "R5 after first ext", 64'(out_valid), 64'h0);
    step(1'b1, 16'hBEEF, 1'b1, took);
    step(1'b0, 16'h0, 1'b1, took);
    chk(expq.size() == 0, "R3 record seen", 64'(expq.size()), 64'h0);

    // R4: source field ignored in immediate mode
    queue_instr(hw(4, 3, 15, 1), 16'h1234, 16'h0, "R4");
    queue_instr(hw(9, 3, 10, 2), 16'h00AB, 16'hCDEF, "R4");
    run(100);

    // R6: backpressure stalls input and holds outputs
    h1 = hw(1, 0, 2, 4);
    h2 = hw(7, 1, 6, 8);
    push_exp(h1, 16'h0, 16'h0, "R6");
    push_exp(h2, 16'h0, 16'h0, "R6");
    step(1'b1, h1, 1'b0, took);
    chk(took, "R6 first accepted", 64'(took), 64'h1);
    step(1'b1, h2, 1'b0, took);
    chk(!took, "R6 in_ready low", 64'(took), 64'h0);
    dsave = out_dst;
    step(1'b1, h2, 1'b0, took);
    chk(!took, "R6 still stalled", 64'(took), 64'h0);
    chk(out_valid && out_dst == dsave, "R6 held", 64'(out_dst), 64'(dsave));
    step(1'b1, h2, 1'b1, took);
    chk(took, "R6 resume", 64'(took), 64'h1);
    step(1'b0, 16'h0, 1'b1, took);
    chk(expq.size() == 0, "R6 both records", 64'(expq.size()), 64'h0);

    // R7: stack-pointer group
    queue_instr(hw(6'h3C, 0, 5, 0), 16'h0, 16'h0, "R7");
    queue_instr(hw(6'h3E, 3, 0, 0), 16'hFFF0, 16'h0, "R7");
    queue_instr(hw(6'h3F, 3, 0, 0), 16'h0001, 16'h0000, "R7");
    run(100);

    // R8: illegal opcode in immediate mode consumes no extension word
    queue_instr(hw(6'h25, 3, 4, 5), 16'h0, 16'h0, "R8");
    queue_instr(hw(6'h3B, 3, 1, 1), 16'h0, 16'h0, "R8");
    queue_instr(hw(0, 1, 2, 3), 16'h0, 16'h0, "R8");
    run(100);

    // R9: reset in the middle of a long immediate discards it
    step(1'b1, hw(11, 3, 0, 6), 1'b1, took);
    step(1'b1, 16'h5555, 1'b1, took);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    chk(out_valid == 1'b0, "R9 mid reset", 64'(out_valid), 64'h0);
    queue_instr(hw(8, 2, 3, 12), 16'h0, 16'h0, "R9");
    run(100);

    // Random mix under varied backpressure
    for (int i = 0; i < 400; i++) begin
      int o;
      int r;
      r = $urandom % 8;
      o = (r == 0) ? 32 + ($urandom % 28) : (r == 1) ? 60 + ($urandom % 4) : ($urandom % 32);
      queue_instr(hw(o, $urandom % 4, $urandom % 16, $urandom % 16),
                  16'($urandom), 16'($urandom), "");
      if ((i % 40) == 39) run(20 + (i % 80));
    end
    run(60);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule